// File: doc/BRIEF.md
# Trigger and Spill Inhibit Controller

This block decides which trigger events a front-end board accepts and tracks the spill structure those triggers fall into. A trigger comes from one of three places: an external line (either a plain pulse, whose rising edge counts, or a one-cycle flag already decoded from an FM-encoded message stream), a software strobe written through the register port, or an internal test pulser. Two sticky latches can block acceptance. One sets on every accepted trigger. The other sets at the end of each spill. A request to release the spill latch is held back until the running spill has closed.

The spill gate either follows an external gate input or is produced by an internal generator. The generator makes one spill or repeating spills, and both the spill length and the gap are counted in whole seconds. During an internal spill a phase accumulator produces test pulses at a programmable rate. Each test pulse reaches the trigger logic after a programmable number of clock ticks. The block counts spills and the triggers accepted inside the current spill.

The register port is a plain write strobe with address and data and has no back-pressure. Addresses: 0 control, 1 test-pulse frequency word, 2 spill length in seconds, 3 inter-spill gap in seconds, 4 test-pulse delay in clock ticks. Control bits: 0 software trigger strobe, 1 trigger source (0 pulse, 1 FM flag), 2 clear trigger inhibit strobe, 3 trigger inhibit enable, 5 spill inhibit clear request strobe, 6 spill inhibit enable, 8 test pulser enable, 9 single spill (1) or continuous (0). Bits 0, 2 and 5 act only in the write that carries them. The other bits hold their value until the next control write.

Top module: `trig_spill_ctrl`

## Requirements
- R1: After reset, trig_o, spill_gate_o, spill_end_o, both inhibit flags and both counters are 0.
- R2: A control write with bit 0 set gives exactly one trig_o pulse. A later control write with bit 0 clear gives none.
- R3: With control bit 1 = 0, each rising edge of trig_pulse_i gives one trigger, a level held high gives only one, and trig_fm_flag_i is ignored. With bit 1 = 1, each cycle with trig_fm_flag_i high gives one trigger, and trig_pulse_i is ignored.
- R4: With control bit 3 set, an accepted trigger sets trig_inhibit_o, and while it is set no trigger is accepted. A control write with bit 2 set clears it.
- R5: With control bit 6 set, spill_inhibit_o sets at each spill end, and while it is set no trigger is accepted.
- R6: A spill-inhibit clear request (control bit 5) written while the spill gate is high leaves the flag set until the gate has gone low. It then clears the flag.
- R7: With control bits 8 and 9 set, exactly one internal spill of length×TICKS_PER_SEC cycles is produced. No other spill follows until bit 8 is cleared and set again.
- R8: With bit 8 set and bit 9 clear, internal spills of length×TICKS_PER_SEC high cycles repeat, separated by gap×TICKS_PER_SEC low cycles.
- R9: Test triggers come from a phase accumulator that adds the frequency word every cycle of an internal spill and pulses on carry-out. A frequency word of 0 gives no test trigger, and no test trigger is issued outside an internal spill.
- R10: Each test pulse reaches the trigger logic delay+1 cycles after the carry. A delay of D moves the first test trigger of a spill exactly D cycles later than a delay of 0 does.
- R11: spill_count_o increments once at each spill start. spill_trig_count_o restarts at each spill start, counts accepted triggers while the gate is high, and holds after the gate falls.
- R12: With bit 8 clear, spill_gate_o follows ext_spill_gate_i one cycle late. spill_end_o is a one-cycle pulse in the first cycle the gate is low.
- R13: A reset clears both inhibit flags, both counters and any pending spill-inhibit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous general reset |
| trig_pulse_i | input | 1 | External trigger, pulse form |
| trig_fm_flag_i | input | 1 | External trigger flag decoded from FM stream |
| ext_spill_gate_i | input | 1 | External spill gate |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| trig_o | output | 1 | Accepted trigger strobe |
| spill_gate_o | output | 1 | Active spill gate |
| spill_end_o | output | 1 | End-of-spill pulse |
| spill_count_o | output | SPILL_CNT_W | Spill counter |
| spill_trig_count_o | output | TRIG_CNT_W | Triggers accepted in current spill |
| trig_inhibit_o | output | 1 | Trigger inhibit flag |
| spill_inhibit_o | output | 1 | Spill inhibit flag |

## Verification
A vector table drives each trigger source under both source settings, so a trigger that leaks from the unselected source shows up as a wrong pulse count. Held levels and multi-cycle FM flags separate edge detection from level sampling. External-gate spills check the counters, the end pulse and the deferred inhibit clear. Internal spills in both modes are timed cycle-exactly, and the first test trigger is measured at two delay settings, which isolates the delay from the accumulator phase.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int A_CTRL = 0;
  localparam int A_FREQ = 1;
  localparam int A_LEN  = 2;
  localparam int A_GAP  = 3;
  localparam int A_DLY  = 4;

  localparam int CB_SW_TRIG   = 0;
  localparam int CB_SRC_FM    = 1;
  localparam int CB_TINH_CLR  = 2;
  localparam int CB_TINH_EN   = 3;
  localparam int CB_SINH_CLR  = 5;
  localparam int CB_SINH_EN   = 6;
  localparam int CB_PULSER_EN = 8;
  localparam int CB_ONE_SHOT  = 9;

  typedef struct packed {
    logic src_fm;
    logic tinh_en;
    logic sinh_en;
    logic pulser_en;
    logic one_shot;
  } cfg_t;

  typedef enum logic [1:0] {SG_IDLE, SG_ON, SG_GAP, SG_DONE} sg_state_t;
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int FREQ_W = 32,
  parameter int SEC_W  = 16,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg,
  output logic [FREQ_W-1:0] freq,
  output logic [SEC_W-1:0]  len_s,
  output logic [SEC_W-1:0]  gap_s,
  output logic [DLY_W-1:0]  dly,
  output logic              sw_trig,
  output logic              tinh_clr,
  output logic              sinh_clr
);
  logic ctl_wr;
  logic unused_data;

  assign ctl_wr      = wr_en && (addr == ADDR_W'(A_CTRL));
  assign unused_data = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      freq     <= '0;
      len_s    <= '0;
      gap_s    <= '0;
      dly      <= '0;
      sw_trig  <= 1'b0;
      tinh_clr <= 1'b0;
      sinh_clr <= 1'b0;
    end else begin
      // strobes live for one cycle only
      sw_trig  <= ctl_wr && wdata[CB_SW_TRIG];
      tinh_clr <= ctl_wr && wdata[CB_TINH_CLR];
      sinh_clr <= ctl_wr && wdata[CB_SINH_CLR];
      if (ctl_wr) begin
        cfg.src_fm    <= wdata[CB_SRC_FM];
        cfg.tinh_en   <= wdata[CB_TINH_EN];
        cfg.sinh_en   <= wdata[CB_SINH_EN];
        cfg.pulser_en <= wdata[CB_PULSER_EN];
        cfg.one_shot  <= wdata[CB_ONE_SHOT];
      end
      if (wr_en && addr == ADDR_W'(A_FREQ)) freq  <= wdata[FREQ_W-1:0];
      if (wr_en && addr == ADDR_W'(A_LEN))  len_s <= wdata[SEC_W-1:0];
      if (wr_en && addr == ADDR_W'(A_GAP))  gap_s <= wdata[SEC_W-1:0];
      if (wr_en && addr == ADDR_W'(A_DLY))  dly   <= wdata[DLY_W-1:0];
    end
  end
endmodule

// File: rtl/tsc_spill_gen.sv
module tsc_spill_gen
  import tsc_pkg::*;
#(
  parameter int SEC_W         = 16,
  parameter int TICKS_PER_SEC = 159235669
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             one_shot,
  input  logic [SEC_W-1:0] len_s,
  input  logic [SEC_W-1:0] gap_s,
  output logic             gate
);
  localparam int TPS_W = $clog2(TICKS_PER_SEC + 1);
  localparam int CNT_W = SEC_W + TPS_W;

  sg_state_t        st;
  logic [CNT_W-1:0] cnt;

  // cycles-1 for a span of whole seconds, at least one cycle
  function automatic logic [CNT_W-1:0] span(input logic [SEC_W-1:0] s);
    logic [CNT_W-1:0] p;
    p = CNT_W'(s) * CNT_W'(TICKS_PER_SEC);
    return (p == '0) ? '0 : p - CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SG_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        SG_IDLE: if (en) begin
          st  <= SG_ON;
          cnt <= span(len_s);
        end
        SG_ON: begin
          if (!en) st <= SG_IDLE;
          else if (cnt == '0) begin
            if (one_shot) st <= SG_DONE;
            else begin
              st  <= SG_GAP;
              cnt <= span(gap_s);
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        SG_GAP: begin
          if (!en) st <= SG_IDLE;
          else if (cnt == '0) begin
            st  <= SG_ON;
            cnt <= span(len_s);
          end else cnt <= cnt - CNT_W'(1);
        end
        SG_DONE: if (!en) st <= SG_IDLE;
        default: st <= SG_IDLE;
      endcase
    end
  end

  assign gate = (st == SG_ON);

  // single spill mode never restarts while still enabled
  assert_oneshot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SG_DONE && en) |=> (st == SG_DONE));
endmodule

// File: rtl/tsc_test_pulser.sv
module tsc_test_pulser #(
  parameter int FREQ_W = 32,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [FREQ_W-1:0] freq,
  input  logic [DLY_W-1:0]  dly,
  output logic              fire
);
  logic [FREQ_W-1:0] acc;
  logic [FREQ_W:0]   sum;
  logic              carry;
  logic              busy;
  logic [DLY_W-1:0]  dcnt;

  assign sum   = {1'b0, acc} + {1'b0, freq};
  assign carry = run && sum[FREQ_W];
  assign fire  = run && busy && (dcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      busy <= 1'b0;
      dcnt <= '0;
    end else begin
      acc <= run ? sum[FREQ_W-1:0] : '0;
      if (!run) busy <= 1'b0;
      else if (carry && (!busy || fire)) begin
        busy <= 1'b1;
        dcnt <= dly;
      end else if (fire) busy <= 1'b0;
      else if (busy) dcnt <= dcnt - DLY_W'(1);
    end
  end
endmodule

// File: rtl/trig_spill_ctrl.sv
module trig_spill_ctrl
  import tsc_pkg::*;
#(
  parameter int ADDR_W        = 3,
  parameter int DATA_W        = 32,
  parameter int FREQ_W        = 32,
  parameter int SEC_W         = 16,
  parameter int DLY_W         = 8,
  parameter int SPILL_CNT_W   = 16,
  parameter int TRIG_CNT_W    = 32,
  parameter int TICKS_PER_SEC = 159235669
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig_pulse_i,
  input  logic                   trig_fm_flag_i,
  input  logic                   ext_spill_gate_i,
  input  logic                   reg_wr_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  output logic                   trig_o,
  output logic                   spill_gate_o,
  output logic                   spill_end_o,
  output logic [SPILL_CNT_W-1:0] spill_count_o,
  output logic [TRIG_CNT_W-1:0]  spill_trig_count_o,
  output logic                   trig_inhibit_o,
  output logic                   spill_inhibit_o
);
  cfg_t              cfg;
  logic [FREQ_W-1:0] freq;
  logic [SEC_W-1:0]  len_s, gap_s;
  logic [DLY_W-1:0]  dly;
  logic              sw_trig, tinh_clr, sinh_clr;
  logic              gen_gate, test_fire;
  logic              pulse_prev, ext_evt, accept;
  logic              gate_nx, spill_start, spill_end_now;
  logic              sinh_pend, sinh_clr_now;

  tsc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FREQ_W(FREQ_W),
             .SEC_W(SEC_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .cfg(cfg), .freq(freq), .len_s(len_s),
    .gap_s(gap_s), .dly(dly), .sw_trig(sw_trig), .tinh_clr(tinh_clr),
    .sinh_clr(sinh_clr));

  tsc_spill_gen #(.SEC_W(SEC_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_gen (
    .clk(clk), .rst_n(rst_n), .en(cfg.pulser_en), .one_shot(cfg.one_shot),
    .len_s(len_s), .gap_s(gap_s), .gate(gen_gate));

  tsc_test_pulser #(.FREQ_W(FREQ_W), .DLY_W(DLY_W)) u_pulser (
    .clk(clk), .rst_n(rst_n), .run(gen_gate), .freq(freq), .dly(dly),
    .fire(test_fire));

  // source selection: pulse edge or decoded FM flag
  assign ext_evt = cfg.src_fm ? trig_fm_flag_i : (trig_pulse_i && !pulse_prev);
  assign accept  = (sw_trig || ext_evt || test_fire) &&
                   !trig_inhibit_o && !spill_inhibit_o;

  assign gate_nx       = cfg.pulser_en ? gen_gate : ext_spill_gate_i;
  assign spill_start   = gate_nx && !spill_gate_o;
  assign spill_end_now = spill_gate_o && !gate_nx;
  assign sinh_clr_now  = sinh_pend && !spill_gate_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_prev         <= 1'b0;
      trig_o             <= 1'b0;
      spill_gate_o       <= 1'b0;
      spill_end_o        <= 1'b0;
      spill_count_o      <= '0;
      spill_trig_count_o <= '0;
      trig_inhibit_o     <= 1'b0;
      spill_inhibit_o    <= 1'b0;
      sinh_pend          <= 1'b0;
    end else begin
      pulse_prev   <= trig_pulse_i;
      trig_o       <= accept;
      spill_gate_o <= gate_nx;
      spill_end_o  <= spill_end_now;

      if (spill_start) begin
        spill_count_o      <= spill_count_o + SPILL_CNT_W'(1);
        spill_trig_count_o <= accept ? TRIG_CNT_W'(1) : '0;
      end else if (gate_nx && accept)
        spill_trig_count_o <= spill_trig_count_o + TRIG_CNT_W'(1);

      if (tinh_clr) trig_inhibit_o <= 1'b0;
      else if (accept && cfg.tinh_en) trig_inhibit_o <= 1'b1;

      // the clear waits for a closed gate
      if (spill_end_now && cfg.sinh_en) spill_inhibit_o <= 1'b1;
      else if (sinh_clr_now) spill_inhibit_o <= 1'b0;

      if (sinh_clr) sinh_pend <= 1'b1;
      else if (sinh_clr_now) sinh_pend <= 1'b0;
    end
  end

  assert_tinh_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_inhibit_o |=> !trig_o);
  assert_sinh_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spill_inhibit_o |=> !trig_o);
  assert_clear_deferred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spill_inhibit_o) |-> !$past(spill_gate_o));
  assert_count_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_count_o != $past(spill_count_o)) |-> $rose(spill_gate_o));
  assert_end_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    spill_end_o |-> (!spill_gate_o && $past(spill_gate_o)));
endmodule

// File: tb/trig_spill_ctrl_test.sv
`timescale 1ns/1ps
module trig_spill_ctrl_test;
  localparam int TPS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_pulse_i = 1'b0, trig_fm_flag_i = 1'b0, ext_spill_gate_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        trig_o, spill_gate_o, spill_end_o, trig_inhibit_o, spill_inhibit_o;
  logic [15:0] spill_count_o;
  logic [31:0] spill_trig_count_o;

  int checks = 0, errors = 0;
  int cyc = 0, ntrig = 0, nend = 0, gcnt = 0, t_gate = 0, t_trig = 0;
  bit gate_seen = 0, trig_seen = 0;

  always #2.5 clk = ~clk;

  trig_spill_ctrl #(.TICKS_PER_SEC(TPS)) uut (.*);

  always @(posedge clk) begin
    cyc++;
    if (trig_o) ntrig++;
    if (spill_end_o) nend++;
    if (spill_gate_o) gcnt++;
    if (spill_gate_o && !gate_seen) begin gate_seen = 1; t_gate = cyc; end
    if (trig_o && !trig_seen) begin trig_seen = 1; t_trig = cyc; end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input longint d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = 32'(d);
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic clr_mon();
    ntrig = 0; nend = 0; gcnt = 0; gate_seen = 0; trig_seen = 0;
  endtask

  task automatic pulse_edge();
    @(negedge clk); trig_pulse_i = 1'b1;
    @(negedge clk); trig_pulse_i = 1'b0;
  endtask

  // {src_fm, pulse, fm, sw, expected}
  localparam logic [4:0] VEC [0:5] = '{
    5'b0_1_0_0_1, 5'b0_0_1_0_0, 5'b1_0_1_0_1,
    5'b1_1_0_0_0, 5'b0_0_0_1_1, 5'b1_0_0_1_1};

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0, d6;
    tick(4);
    check("R1 trig", trig_o, 0);
    check("R1 gate", spill_gate_o, 0);
    check("R1 counters", spill_count_o + spill_trig_count_o, 0);
    check("R1 flags", trig_inhibit_o + spill_inhibit_o, 0);
    rst_n = 1'b1;
    tick(2);

    // R3 and R2 source table
    for (int i = 0; i < 6; i++) begin
      wr(0, longint'(VEC[i][4]) << 1);
      tick(2);
      clr_mon();
      if (VEC[i][1]) wr(0, (longint'(VEC[i][4]) << 1) | 1);
      else begin
        @(negedge clk); trig_pulse_i = VEC[i][3]; trig_fm_flag_i = VEC[i][2];
        @(negedge clk); trig_pulse_i = 1'b0; trig_fm_flag_i = 1'b0;
      end
      tick(4);
      check($sformatf("R3 R2 vector %0d", i), ntrig, VEC[i][0]);
    end

    // R2 bit 0 does not stay set
    clr_mon(); wr(0, 0); tick(4);
    check("R2 no repeat", ntrig, 0);

    // R3 held level counts once; FM flag counts per cycle
    clr_mon();
    @(negedge clk); trig_pulse_i = 1'b1; tick(5); trig_pulse_i = 1'b0; tick(3);
    check("R3 held pulse", ntrig, 1);
    wr(0, 1 << 1); clr_mon();
    @(negedge clk); trig_fm_flag_i = 1'b1; tick(3); trig_fm_flag_i = 1'b0; tick(3);
    check("R3 fm multi", ntrig, 3);

    // R4 trigger inhibit
    wr(0, 1 << 3); tick(1); clr_mon();
    pulse_edge(); tick(3);
    check("R4 first", ntrig, 1);
    check("R4 flag set", trig_inhibit_o, 1);
    pulse_edge(); tick(3);
    check("R4 blocked", ntrig, 1);
    wr(0, (1 << 3) | (1 << 2)); tick(2);
    check("R4 cleared", trig_inhibit_o, 0);
    pulse_edge(); tick(3);
    check("R4 after clear", ntrig, 2);
    wr(0, 0); wr(0, 1 << 2); tick(2);

    // R11 R12 external gate
    clr_mon();
    @(negedge clk); ext_spill_gate_i = 1'b1;
    @(negedge clk);
    check("R12 gate follows", spill_gate_o, 1);
    check("R11 spill count", spill_count_o, 1);
    pulse_edge(); pulse_edge(); pulse_edge(); tick(2);
    check("R11 trig count", spill_trig_count_o, 3);
    @(negedge clk); ext_spill_gate_i = 1'b0;
    @(negedge clk);
    check("R12 gate low", spill_gate_o, 0);
    check("R12 end pulse", spill_end_o, 1);
    pulse_edge(); tick(3);
    check("R12 end single", nend, 1);
    check("R11 hold after", spill_trig_count_o, 3);
    @(negedge clk); ext_spill_gate_i = 1'b1; tick(2);
    check("R11 restart", spill_trig_count_o, 0);
    check("R11 spill two", spill_count_o, 2);
    @(negedge clk); ext_spill_gate_i = 1'b0; tick(3);

    // R5 R6 spill inhibit
    wr(0, 1 << 6); tick(1);
    @(negedge clk); ext_spill_gate_i = 1'b1; tick(3);
    @(negedge clk); ext_spill_gate_i = 1'b0; tick(3);
    check("R5 flag set", spill_inhibit_o, 1);
    clr_mon(); pulse_edge(); tick(3);
    check("R5 blocked", ntrig, 0);
    @(negedge clk); ext_spill_gate_i = 1'b1; tick(2);
    wr(0, (1 << 6) | (1 << 5)); tick(6);
    check("R6 deferred", spill_inhibit_o, 1);
    @(negedge clk); ext_spill_gate_i = 1'b0; tick(4);
    check("R6 cleared", spill_inhibit_o, 0);
    clr_mon(); pulse_edge(); tick(3);
    check("R6 accepts", ntrig, 1);

    // R13 reset clears latches, counters and pending clear
    wr(0, (1 << 6) | (1 << 3));
    pulse_edge();
    @(negedge clk); ext_spill_gate_i = 1'b1; tick(2);
    wr(0, (1 << 6) | (1 << 3) | (1 << 5));
    @(negedge clk); rst_n = 1'b0; ext_spill_gate_i = 1'b0; tick(3);
    rst_n = 1'b1; tick(3);
    check("R13 tinh", trig_inhibit_o, 0);
    check("R13 sinh", spill_inhibit_o, 0);
    check("R13 counters", spill_count_o + spill_trig_count_o, 0);
    wr(0, 1 << 6);
    @(negedge clk); ext_spill_gate_i = 1'b1; tick(2);
    @(negedge clk); ext_spill_gate_i = 1'b0; tick(6);
    check("R13 no stale clear", spill_inhibit_o, 1);
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);

    // R7 R9 single internal spill, zero rate
    wr(2, 3); wr(1, 0);
    clr_mon();
    wr(0, (1 << 8) | (1 << 9)); tick(80);
    check("R7 length", gcnt, 3 * TPS);
    check("R7 one spill", spill_count_o, 1);
    check("R9 zero rate", ntrig, 0);

    // R8 continuous spills
    wr(0, 0); wr(2, 2); wr(3, 1); tick(3);
    clr_mon();
    wr(0, 1 << 8); tick(100);
    check("R8 ends", nend, 3);
    check("R8 starts", spill_count_o, 5);
    wr(0, 0); tick(8);

    // R9 R10 test pulses and delay
    wr(1, 64'h8000_0000); wr(2, 2); wr(4, 0); tick(3);
    clr_mon();
    wr(0, (1 << 8) | (1 << 9)); tick(40);
    d0 = t_trig - t_gate;
    checks++;
    if (ntrig < 8 || ntrig > 10) begin
      errors++; $display("FAIL R9 rate actual=%0d expected=8..10", ntrig);
    end
    clr_mon(); tick(20);
    check("R9 none outside spill", ntrig, 0);
    wr(0, 0); wr(4, 6); tick(3);
    clr_mon();
    wr(0, (1 << 8) | (1 << 9)); tick(40);
    d6 = t_trig - t_gate;
    check("R10 delay shift", d6 - d0, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule